// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 16 bits. The RAM has one active-low chip select, one output enable, one write strobe and two active-low lane selects, one for each byte. The host hands over one request at a time with a request/ready handshake. A request carries a word address, write data, a two-bit lane mask and a read/write flag. Reads return the selected bytes on a response bus, with a one-cycle valid strobe.

Every phase on the memory side is stretched by a whole number of clock cycles. Each count is computed at elaboration from a nanosecond limit and the clock period. The memory address and lane selects are registered once per access and stay fixed until the access ends. The write strobe sits strictly inside that window, with one cycle of setup before it and one cycle of recovery after it. The controller drives the shared data bus only during the strobe and one hold cycle after it, and it never drives the bus while the memory's outputs are enabled.

The controller is one state machine with six states. IDLE: ready, memory deselected. WSETUP: address, lanes and chip select applied. WPULSE: write strobe low. WHOLD: strobe released, data still driven. RACCESS: output enable low while the data settles. RFLOAT: output enable released while the memory's drivers float. The transitions are:
- IDLE→WSETUP on an accepted write.
- IDLE→RACCESS on an accepted read.
- WSETUP→WPULSE after one cycle.
- WPULSE→WHOLD when the pulse count ends.
- WHOLD→IDLE after one cycle.
- RACCESS→RFLOAT when the access count ends, with data captured on that edge.
- RFLOAT→IDLE when the float count ends.

Top module: `bytelane_sram_ctl`

## Requirements
- R1: After reset and while idle, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are high, mem_dq_oe is low, req_ready is high and rsp_valid is low.
- R2: req_ready is high only in IDLE. A request is taken on a clock edge where req_valid and req_ready are both high, and req_ready is low in the cycle after that edge.
- R3: A write changes only the lanes whose mask bit is set: req_be[0] selects bits 7:0 via mem_lb_n, req_be[1] selects bits 15:8 via mem_ub_n. Lanes with a clear mask bit keep their previous contents, and a mask of 00 writes nothing.
- R4: A read returns the memory's byte on each lane whose mask bit is set. Lanes with a clear mask bit read as zero in rsp_rdata.
- R5: rsp_valid is a single-cycle pulse. It goes high RD_WAIT+1 clock edges after the edge that accepted the read, where RD_WAIT = max(1, ceil(access time / clock period)); the default is 6.
- R6: mem_we_n is low for exactly WP_WAIT consecutive cycles. The cycle before and the cycle after the pulse both have mem_ce_n low with the same address and lane selects. WP_WAIT = max(1, ceil(pulse limit / period), ceil(write cycle / period) − 2); the default is 4.
- R7: While mem_ce_n stays low, mem_addr, mem_lb_n and mem_ub_n do not change.
- R8: mem_dq_oe is high only while mem_we_n is low or in the one cycle after it rises. It is never high while mem_oe_n is low.
- R9: mem_oe_n is low only with mem_ce_n low and mem_we_n high. mem_dq_oe is already low in the cycle before mem_oe_n falls.
- R10: After a read, FL_WAIT = max(1, ceil(output float time / period)) cycles pass with mem_oe_n high before req_ready returns. The default is 2, so req_ready returns RD_WAIT+FL_WAIT+1 edges after acceptance.
- R11: A write holds mem_ce_n low for WP_WAIT+2 cycles, and that span is at least the write cycle time. req_ready returns WP_WAIT+3 edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_be | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_lb_n | output | 1 | Low byte lane select, active low |
| mem_ub_n | output | 1 | High byte lane select, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned from the memory |

## Verification
A wrong state or a miscounted phase shows at the memory pins within one access. A strobe that is too short, a missing setup or recovery cycle, or an address that moves under chip select is visible on the next clock edge. A bus left driven while output enable falls is reported in the cycle of contention. A wrong access count shifts the response strobe by whole cycles, or returns bytes that the memory model marks as not yet settled. A wrong lane decode leaves stale or extra bytes that show up when the same word is read back later.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS,
        ST_RFLOAT
    } bls_state_e;

    // whole cycles covering a nanosecond limit, never below one
    function automatic int cycles_for(input int limit_ns, input int period_ns);
        int c;
        c = (limit_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bls_fsm.sv
module bls_fsm
    import bls_pkg::*;
#(
    parameter int RD_WAIT = 6,
    parameter int WP_WAIT = 4,
    parameter int FL_WAIT = 2,
    parameter int CNT_W   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_we,
    output logic req_ready,
    output logic load,
    output logic capture,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic lanes_on,
    output logic dq_oe
);

    bls_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // final cycle of the current timed phase
    always_comb begin
        last = 1'b1;
        unique case (state_q)
            ST_WPULSE:  last = (cnt_q == CNT_W'(WP_WAIT - 1));
            ST_RACCESS: last = (cnt_q == CNT_W'(RD_WAIT - 1));
            ST_RFLOAT:  last = (cnt_q == CNT_W'(FL_WAIT - 1));
            default:    last = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = req_we ? ST_WSETUP : ST_RACCESS;
            ST_WSETUP:  state_d = ST_WPULSE;
            ST_WPULSE:  if (last) state_d = ST_WHOLD;
            ST_WHOLD:   state_d = ST_IDLE;
            ST_RACCESS: if (last) state_d = ST_RFLOAT;
            ST_RFLOAT:  if (last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register with phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        ce_n      = 1'b0;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        lanes_on  = 1'b1;
        dq_oe     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                ce_n      = 1'b1;
                lanes_on  = 1'b0;
            end
            ST_WSETUP:  ;
            ST_WPULSE: begin
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WHOLD:   dq_oe = 1'b1;
            ST_RACCESS: oe_n  = 1'b0;
            ST_RFLOAT:  ;
            default:    ;
        endcase
    end

    assign load    = req_ready & req_valid;
    assign capture = (state_q == ST_RACCESS) & last;

endmodule

// File: rtl/bls_datapath.sv
module bls_datapath #(
    parameter int AW = 17,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          capture,
    input  logic          lanes_on,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_be,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    lane_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    localparam int LW = DW / 2;

    logic [AW-1:0] addr_q;
    logic [1:0]    be_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] masked;
    logic          valid_q;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_n[g]          = ~(lanes_on & be_q[g]);
        assign masked[g*LW +: LW] = be_q[g] ? mem_dq_i[g*LW +: LW] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            valid_q <= 1'b0;
        end else begin
            if (load) begin
                addr_q  <= req_addr;
                be_q    <= req_be;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= masked;
            valid_q <= capture;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign rsp_valid = valid_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/bytelane_sram_ctl.sv
module bytelane_sram_ctl
    import bls_pkg::*;
#(
    parameter int AW            = 17,
    parameter int DW            = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ACCESS_NS   = 55,
    parameter int T_WPULSE_NS   = 40,
    parameter int T_WCYCLE_NS   = 55,
    parameter int T_FLOAT_NS    = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_be,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    localparam int RD_WAIT = cycles_for(T_ACCESS_NS, CLK_PERIOD_NS);
    localparam int WP_WAIT = max2(cycles_for(T_WPULSE_NS, CLK_PERIOD_NS),
                                  cycles_for(T_WCYCLE_NS, CLK_PERIOD_NS) - 2);
    localparam int FL_WAIT = cycles_for(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int CNT_W   = $clog2(max2(max2(RD_WAIT, WP_WAIT), FL_WAIT) + 1);

    logic       load, capture, lanes_on;
    logic [1:0] lane_n;

    bls_fsm #(
        .RD_WAIT(RD_WAIT),
        .WP_WAIT(WP_WAIT),
        .FL_WAIT(FL_WAIT),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_we   (req_we),
        .req_ready(req_ready),
        .load     (load),
        .capture  (capture),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .lanes_on (lanes_on),
        .dq_oe    (mem_dq_oe)
    );

    bls_datapath #(
        .AW(AW),
        .DW(DW)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .capture  (capture),
        .lanes_on (lanes_on),
        .req_addr (req_addr),
        .req_be   (req_be),
        .req_wdata(req_wdata),
        .mem_dq_i (mem_dq_i),
        .mem_addr (mem_addr),
        .lane_n   (lane_n),
        .mem_dq_o (mem_dq_o),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];

endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
    parameter int AW      = 17,
    parameter int WP_WAIT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_lb_n,
    input logic          mem_ub_n,
    input logic          mem_dq_oe
);

    logic [7:0] wlow_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wlow_cnt <= '0;
        else        wlow_cnt <= mem_we_n ? 8'd0 : wlow_cnt + 8'd1;
    end

    p_idle_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_we_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wlow_cnt == 8'(WP_WAIT)));

    p_we_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_ce_n));

    p_we_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n);

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |->
            ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

    p_drive_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n || !$past(mem_we_n)));

    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_oe_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    p_release_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

endmodule

bind bytelane_sram_ctl bls_checker #(
    .AW     (AW),
    .WP_WAIT(WP_WAIT)
) u_bls_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_bytelane_sram_ctl.sv
module test_bytelane_sram_ctl;

    localparam int PERIOD = 10;
    localparam int TAA    = 55;
    localparam int TWP    = 40;
    localparam int TWC    = 55;
    localparam int TOHZ   = 20;
    // expected counts, worked out from the requirements
    localparam int RD_EXP   = (TAA + PERIOD - 1) / PERIOD;
    localparam int WP_A     = (TWP + PERIOD - 1) / PERIOD;
    localparam int WP_B     = (TWC + PERIOD - 1) / PERIOD - 2;
    localparam int WP_EXP   = (WP_A > WP_B) ? WP_A : WP_B;
    localparam int FL_EXP   = (TOHZ + PERIOD - 1) / PERIOD;
    localparam int ACC_NEG  = (TAA + PERIOD / 2 + PERIOD - 1) / PERIOD;
    localparam int WC_NEG   = (TWC + PERIOD - 1) / PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD / 2) clk = ~clk;

    bytelane_sram_ctl i_bytelane_sram_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] seed_word(input int i);
        return 16'(i * 16'h0131) ^ 16'h5AC3;
    endfunction

    // behavioural memory, 256 words, aliased on the low address bits
    logic [15:0] mem    [256];
    logic [15:0] shadow [256];
    int          acc = 0;
    int          wcnt = 0;
    int          cecnt = 0;
    bit          ce_wr = 0;
    logic [15:0] wdat;
    logic [1:0]  wln;
    logic [7:0]  wadr;
    logic [16:0] paddr = '0;
    logic [1:0]  pln = 2'b11;
    logic        pce_low = 1'b0;

    initial for (int i = 0; i < 256; i++) begin
        mem[i]    = seed_word(i);
        shadow[i] = seed_word(i);
    end

    logic rd_ok;
    always_comb begin
        rd_ok = !mem_ce_n && !mem_oe_n && mem_we_n && (acc >= ACC_NEG);
        mem_dq_i[7:0]  = !mem_lb_n ? (rd_ok ? mem[mem_addr[7:0]][7:0]  : 8'h5A) : 8'hA5;
        mem_dq_i[15:8] = !mem_ub_n ? (rd_ok ? mem[mem_addr[7:0]][15:8] : 8'h5A) : 8'hA5;
    end

    always @(negedge clk) if (rst_n) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe) acc = acc + 1;
        else acc = 0;
        if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n)
            check(0, "R8 bus contention", 1, 0);
        if (!mem_ce_n && !mem_we_n) begin
            wcnt  = wcnt + 1;
            ce_wr = 1;
            wdat  = mem_dq_o;
            wln   = {!mem_ub_n, !mem_lb_n};
            wadr  = mem_addr[7:0];
            if (!mem_dq_oe) check(0, "R8 data not driven in pulse", 0, 1);
        end else if (wcnt > 0) begin
            check(wcnt >= WP_A, "R6 pulse width", wcnt, WP_A);
            check(mem_dq_oe == 1'b1, "R8 hold cycle drive", mem_dq_oe, 1);
            if (wln[0]) mem[wadr][7:0]  = wdat[7:0];
            if (wln[1]) mem[wadr][15:8] = wdat[15:8];
            wcnt = 0;
        end
        if (!mem_ce_n) begin
            cecnt = cecnt + 1;
            if (pce_low && (mem_addr != paddr || {mem_ub_n, mem_lb_n} != pln))
                check(0, "R7 address moved under select", mem_addr, paddr);
        end else if (cecnt > 0) begin
            if (ce_wr) check(cecnt >= WC_NEG, "R11 write cycle length", cecnt, WC_NEG);
            cecnt = 0;
            ce_wr = 0;
        end
        pce_low = !mem_ce_n;
        paddr   = mem_addr;
        pln     = {mem_ub_n, mem_lb_n};
    end

    function automatic logic [15:0] lane_mask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic issue(input bit we, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m, output int k_rsp, output int k_rdy,
                         output int n_rsp, output logic [15:0] rdat);
        k_rsp = 0; k_rdy = 0; n_rsp = 0; rdat = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = m;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready drops after accept", req_ready, 0);
        for (int k = 1; k < 60; k++) begin
            if (rsp_valid) begin
                n_rsp++;
                k_rsp = k;
                rdat  = rsp_rdata;
            end
            if (req_ready) begin
                k_rdy = k;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        int kr, ky, n;
        logic [15:0] rd;
        issue(1'b1, a, d, m, kr, ky, n, rd);
        check(ky == WP_EXP + 3, "R11 write completion", ky, WP_EXP + 3);
        check(n == 0, "R5 no strobe on write", n, 0);
        shadow[a[7:0]] = (shadow[a[7:0]] & ~lane_mask(m)) | (d & lane_mask(m));
    endtask

    task automatic do_read(input logic [16:0] a, input logic [1:0] m);
        int kr, ky, n;
        logic [15:0] rd;
        logic [15:0] exp;
        issue(1'b0, a, 16'h0, m, kr, ky, n, rd);
        exp = shadow[a[7:0]] & lane_mask(m);
        check(n == 1 && kr == RD_EXP + 1, "R5 read strobe timing", kr, RD_EXP + 1);
        check(ky == RD_EXP + FL_EXP + 1, "R10 float before ready", ky, RD_EXP + FL_EXP + 1);
        check(rd == exp, (m == 2'b11) ? "R3 read-back" : "R4 lane select", rd, exp);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        // R1 reset state
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'h1F,
              "R1 controls idle in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1F);
        check(!mem_dq_oe && !rsp_valid, "R1 no drive, no strobe", {mem_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
        check(mem_ce_n == 1'b1, "R1 deselected when idle", mem_ce_n, 1);

        // R3 each mask pattern on one word, read back in full
        for (int m = 0; m < 4; m++) begin
            do_write(17'd5, 16'h1111 * 16'(m + 1), 2'(m));
            do_read(17'd5, 2'b11);
        end
        // R4 each read mask
        for (int m = 0; m < 4; m++) do_read(17'd5, 2'(m));
        // boundary addresses
        do_write(17'h00000, 16'hBEEF, 2'b11);
        do_write(17'h1FFFF, 16'hCAFE, 2'b10);
        do_read(17'h00000, 2'b11);
        do_read(17'h1FFFF, 2'b11);
        do_read(17'h1FFFF, 2'b01);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [16:0] a;
            logic [1:0]  m;
            a = 17'($urandom);
            m = 2'($urandom);
            if ($urandom % 2) do_write(a, 16'($urandom), m);
            else              do_read(a, m);
        end
        for (int i = 0; i < 256; i += 17) do_read(17'(i), 2'b11);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule